// File: doc/BRIEF.md
# Flash Address Guard

This block sits beside a serial-flash cycle sequencer and rules, in the same cycle, on whether the cycle about to go out may proceed. It checks two things. The first is a global floor: no flash cycle of any kind may target an address below it. The second is a bank of write-protect windows. Each window has an enable, a first 4 KiB page and an inclusive last page, and stops program and erase cycles that land inside it. Reads are never stopped by a window.

Software sets the guard up through a simple register-write port and can read the registers back. A status register reports a sticky "access refused" flag, which is cleared by writing a one to it. The same register holds a configuration lock. Once the lock is set, the floor and window registers are frozen until reset. The sequencer presents the cycle address and a write/erase flag. It issues the cycle only when the allow output is high.

Top module: `flash_guard`

## Requirements
- R1: A cycle (read or write) whose 24-bit address is below the floor (the low 24 bits of the floor register) is refused; an address equal to the floor is not refused by the floor.
- R2: A write to the floor register (select 0) stores the low 24 data bits with bits 31:24 forced to all ones; the reset value is 0xFF000000, so after reset the floor admits every address.
- R3: A window register holds the enable in bit 31, the last page in bits 23:12 and the first page in bits 11:0, where page = address[23:12]; a write cycle whose page satisfies first <= page <= last in an enabled window is refused, the last page included.
- R4: A window whose enable bit is 0 refuses nothing, whatever its page fields hold.
- R5: Windows affect only cycles with the write/erase flag high; a read at or above the floor is allowed even inside an enabled window.
- R6: Writing status (select 1) with bit 1 set raises the lock; after that, writes to the floor and window registers have no effect, and the lock stays set until reset.
- R7: A refused cycle sets the blocked flag (status bit 0, also driven on `blocked_sts`) at the next clock edge, and it stays set.
- R8: A status write with bit 0 set clears the blocked flag, also while locked; a status write with bit 0 clear leaves it; a refusal in the same cycle as a clear leaves the flag set.
- R9: Selects are 0 floor, 1 status, 2+i window i; `cfg_rdata` returns the selected register (status: bit 0 blocked, bit 1 lock, others 0); unused selects read 0 and ignore writes.
- R10: `cyc_allow` is low whenever `cyc_valid` is low, and a cycle with `cyc_valid` low never sets the blocked flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| cyc_valid | input | 1 | A flash cycle is being proposed |
| cyc_addr | input | 24 | Target address of the proposed cycle |
| cyc_write | input | 1 | Proposed cycle programs or erases |
| cyc_allow | output | 1 | Proposed cycle may be issued |
| blocked_sts | output | 1 | Sticky refused-access flag |

## Verification
The hardest case to reach from the ports is a refusal that lands on the same clock edge as a write that clears the flag. Close behind it is an attempt to rewrite the protection setup after the lock has been set. The bench drives the refused cycle and the clearing status write on the same falling edge, so both take effect at one rising edge. After locking, it tries to overwrite the floor and a window, then repeats part of the address sweep against the unchanged expected setup. The window edges are covered by sweeping every 4 KiB page at both its first and last byte, for reads and for writes.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int REG_W        = 32;
    localparam int EN_BIT       = 31;
    localparam int STS_BLK_BIT  = 0;
    localparam int STS_LOCK_BIT = 1;
    localparam int SEL_FLOOR    = 0;
    localparam int SEL_STATUS   = 1;
    localparam int SEL_WIN0     = 2;

endpackage

// File: rtl/fg_window_cmp.sv
module fg_window_cmp #(
    parameter int PG_W = 12
) (
    input  logic            win_en,
    input  logic [PG_W-1:0] win_first,
    input  logic [PG_W-1:0] win_last,
    input  logic [PG_W-1:0] addr_pg,
    output logic            hit
);

    logic above_first;
    logic below_last;

    always_comb begin
        above_first = (addr_pg >= win_first);
        below_last  = (addr_pg <= win_last);
        hit         = win_en && above_first && below_last;
    end

endmodule

// File: rtl/fg_decide.sv
module fg_decide #(
    parameter int ADDR_W = 24,
    parameter int NWIN   = 4
) (
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [ADDR_W-1:0] floor_lim,
    input  logic [NWIN-1:0]   win_hit,
    output logic              allow,
    output logic              refuse
);

    logic below_floor;
    logic in_window;

    always_comb begin
        below_floor = (cyc_addr < floor_lim);
        in_window   = cyc_write && (|win_hit);
        refuse      = cyc_valid && (below_floor || in_window);
        allow       = cyc_valid && !refuse;
    end

endmodule

// File: rtl/fg_regs.sv
module fg_regs
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PG_W   = 12,
    parameter int NWIN   = 4,
    parameter int SEL_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [REG_W-1:0]          cfg_wdata,
    input  logic                      block_evt,
    output logic [REG_W-1:0]          cfg_rdata,
    output logic [ADDR_W-1:0]         floor_lim,
    output logic [NWIN-1:0]           win_en,
    output logic [NWIN-1:0][PG_W-1:0] win_first,
    output logic [NWIN-1:0][PG_W-1:0] win_last,
    output logic                      blocked,
    output logic                      locked
);

    localparam int TOP_W = REG_W - ADDR_W;

    typedef struct packed {
        logic [REG_W-1:0]            floor;
        logic [NWIN-1:0][REG_W-1:0]  win;
        logic                        blocked;
        logic                        lock;
    } regs_t;

    regs_t st_d, st_q;

    logic sel_status;
    logic sel_floor;

    always_comb begin
        sel_status = (cfg_sel == SEL_W'(SEL_STATUS));
        sel_floor  = (cfg_sel == SEL_W'(SEL_FLOOR));
        st_d       = st_q;
        if (cfg_we) begin
            if (sel_status) begin
                if (cfg_wdata[STS_LOCK_BIT]) st_d.lock    = 1'b1;
                if (cfg_wdata[STS_BLK_BIT])  st_d.blocked = 1'b0;
            end else if (!st_q.lock) begin
                if (sel_floor) begin
                    st_d.floor = {{TOP_W{1'b1}}, cfg_wdata[ADDR_W-1:0]};
                end
                for (int i = 0; i < NWIN; i++) begin
                    if (cfg_sel == SEL_W'(SEL_WIN0 + i)) st_d.win[i] = cfg_wdata;
                end
            end
        end
        if (block_evt) st_d.blocked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.floor   <= {{TOP_W{1'b1}}, {ADDR_W{1'b0}}};
            st_q.win     <= '0;
            st_q.blocked <= 1'b0;
            st_q.lock    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_sel == SEL_W'(SEL_FLOOR)) cfg_rdata = st_q.floor;
        if (cfg_sel == SEL_W'(SEL_STATUS)) begin
            cfg_rdata[STS_BLK_BIT]  = st_q.blocked;
            cfg_rdata[STS_LOCK_BIT] = st_q.lock;
        end
        for (int i = 0; i < NWIN; i++) begin
            if (cfg_sel == SEL_W'(SEL_WIN0 + i)) cfg_rdata = st_q.win[i];
        end
    end

    always_comb begin
        floor_lim = st_q.floor[ADDR_W-1:0];
        blocked   = st_q.blocked;
        locked    = st_q.lock;
        for (int i = 0; i < NWIN; i++) begin
            win_en[i]    = st_q.win[i][EN_BIT];
            win_first[i] = st_q.win[i][PG_W-1:0];
            win_last[i]  = st_q.win[i][2*PG_W-1:PG_W];
        end
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int PAGE_LG2 = 12,
    parameter int NWIN     = 4,
    parameter int SEL_W    = $clog2(NWIN + SEL_WIN0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_write,
    output logic              cyc_allow,
    output logic              blocked_sts
);

    localparam int PG_W = ADDR_W - PAGE_LG2;

    logic [ADDR_W-1:0]         floor_lim;
    logic [NWIN-1:0]           win_en;
    logic [NWIN-1:0][PG_W-1:0] win_first;
    logic [NWIN-1:0][PG_W-1:0] win_last;
    logic [NWIN-1:0]           win_hit;
    logic                      refuse;
    logic                      lock_q;
    logic [PG_W-1:0]           addr_pg;

    assign addr_pg = cyc_addr[ADDR_W-1:PAGE_LG2];

    fg_regs #(
        .ADDR_W(ADDR_W), .PG_W(PG_W), .NWIN(NWIN), .SEL_W(SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .block_evt (refuse),
        .cfg_rdata (cfg_rdata),
        .floor_lim (floor_lim),
        .win_en    (win_en),
        .win_first (win_first),
        .win_last  (win_last),
        .blocked   (blocked_sts),
        .locked    (lock_q)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        fg_window_cmp #(.PG_W(PG_W)) u_cmp (
            .win_en    (win_en[g]),
            .win_first (win_first[g]),
            .win_last  (win_last[g]),
            .addr_pg   (addr_pg),
            .hit       (win_hit[g])
        );
    end

    fg_decide #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_dec (
        .cyc_valid (cyc_valid),
        .cyc_write (cyc_write),
        .cyc_addr  (cyc_addr),
        .floor_lim (floor_lim),
        .win_hit   (win_hit),
        .allow     (cyc_allow),
        .refuse    (refuse)
    );

endmodule

// File: rtl/fg_checker.sv
module fg_checker
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PG_W   = 12,
    parameter int NWIN   = 4,
    parameter int SEL_W  = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [SEL_W-1:0]          cfg_sel,
    input logic [REG_W-1:0]          cfg_wdata,
    input logic                      cyc_valid,
    input logic [ADDR_W-1:0]         cyc_addr,
    input logic                      cyc_write,
    input logic                      cyc_allow,
    input logic                      blocked_sts,
    input logic                      lock_q,
    input logic [ADDR_W-1:0]         floor_lim,
    input logic [NWIN-1:0]           win_en,
    input logic [NWIN-1:0][PG_W-1:0] win_first,
    input logic [NWIN-1:0][PG_W-1:0] win_last
);

    logic clr_wr;
    assign clr_wr = cfg_we && (cfg_sel == SEL_W'(SEL_STATUS)) && cfg_wdata[STS_BLK_BIT];

    a_r1_floor_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && (cyc_addr < floor_lim)) |-> !cyc_allow);

    a_r5_read_free: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_write && (cyc_addr >= floor_lim)) |-> cyc_allow);

    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    a_r6_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(floor_lim) && $stable(win_en)
                    && $stable(win_first) && $stable(win_last)));

    a_r7_block_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_allow) |=> blocked_sts);

    a_r8_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_sts && !clr_wr) |=> blocked_sts);

    a_r10_idle_denied: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |-> !cyc_allow);

    a_r10_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_valid && !blocked_sts) |=> !blocked_sts);

endmodule

bind flash_guard fg_checker #(
    .ADDR_W(ADDR_W), .PG_W(PG_W), .NWIN(NWIN), .SEL_W(SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .cyc_valid   (cyc_valid),
    .cyc_addr    (cyc_addr),
    .cyc_write   (cyc_write),
    .cyc_allow   (cyc_allow),
    .blocked_sts (blocked_sts),
    .lock_q      (lock_q),
    .floor_lim   (floor_lim),
    .win_en      (win_en),
    .win_first   (win_first),
    .win_last    (win_last)
);

// File: tb/sim_flash_guard.sv
module sim_flash_guard;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cyc_valid = 1'b0;
    logic [23:0] cyc_addr = '0;
    logic        cyc_write = 1'b0;
    logic        cyc_allow;
    logic        blocked_sts;

    int checks = 0;
    int errors = 0;

    logic [23:0] sh_floor;
    logic [3:0]  sh_en;
    logic [11:0] sh_first [4];
    logic [11:0] sh_last  [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cyc_valid(cyc_valid),
        .cyc_addr(cyc_addr), .cyc_write(cyc_write), .cyc_allow(cyc_allow),
        .blocked_sts(blocked_sts)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        cfg_sel = sel;
        #1;
        d = cfg_rdata;
    endtask

    task automatic set_win(input int i, input logic en, input logic [11:0] f, input logic [11:0] l);
        wr(3'(2 + i), {en, 7'd0, l, f});
        sh_en[i] = en; sh_first[i] = f; sh_last[i] = l;
    endtask

    function automatic logic exp_allow(input logic [23:0] a, input logic w);
        logic [11:0] pg;
        pg = a[23:12];
        if (a < sh_floor) return 1'b0;
        if (w) begin
            for (int i = 0; i < 4; i++)
                if (sh_en[i] && pg >= sh_first[i] && pg <= sh_last[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic sweep(input int pg_hi);
        for (int p = 0; p < pg_hi; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [23:0] a;
                a = {12'(p), ((k & 1) != 0) ? 12'hFFF : 12'h000};
                cyc_addr = a; cyc_write = (k >= 2); cyc_valid = 1'b1;
                #1;
                if (cyc_allow !== exp_allow(a, cyc_write)) begin
                    if (a < sh_floor) chk("R1 floor sweep", {31'd0, cyc_allow}, 32'd0);
                    else if (!cyc_write) chk("R5 read sweep", {31'd0, cyc_allow}, 32'd1);
                    else chk("R3 R4 window sweep", {31'd0, cyc_allow}, {31'd0, exp_allow(a, 1'b1)});
                end else begin
                    checks++;
                end
            end
        end
        cyc_valid = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        sh_floor = '0; sh_en = '0;
        for (int i = 0; i < 4; i++) begin sh_first[i] = '0; sh_last[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(3'd0, d); chk("R2 floor reset", d, 32'hFF000000);
        rd(3'd1, d); chk("R9 status reset", d, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(3'(2 + i), d); chk("R9 window reset", d, 32'h0);
        end
        chk("R7 blocked reset", {31'd0, blocked_sts}, 32'd0);
        cyc_addr = 24'h000000; cyc_write = 1'b1; cyc_valid = 1'b0;
        #1; chk("R10 idle allow low", {31'd0, cyc_allow}, 32'd0);
        @(negedge clk);
        chk("R10 idle sets nothing", {31'd0, blocked_sts}, 32'd0);
        cyc_valid = 1'b1; #1;
        chk("R2 reset floor admits zero", {31'd0, cyc_allow}, 32'd1);
        cyc_valid = 1'b0;

        // Floor write forces top byte
        wr(3'd0, 32'h12010000); sh_floor = 24'h010000;
        rd(3'd0, d); chk("R2 floor top byte", d, 32'hFF010000);

        // Window setup
        set_win(0, 1'b1, 12'h020, 12'h02F);
        set_win(1, 1'b0, 12'h040, 12'h04F);
        set_win(2, 1'b1, 12'h100, 12'h100);
        set_win(3, 1'b1, 12'hFFF, 12'hFFF);
        rd(3'd2, d); chk("R9 window0 readback", d, 32'h8002F020);
        rd(3'd3, d); chk("R9 window1 readback", d, 32'h0004F040);

        // Unused select
        wr(3'd6, 32'hDEADBEEF);
        rd(3'd6, d); chk("R9 unused select", d, 32'h0);
        rd(3'd7, d); chk("R9 unused select 7", d, 32'h0);

        // Full page sweep
        @(negedge clk);
        sweep(4096);

        // Named boundary checks
        cyc_valid = 1'b1; cyc_write = 1'b0;
        cyc_addr = 24'h00FFFF; #1; chk("R1 below floor read", {31'd0, cyc_allow}, 32'd0);
        cyc_addr = 24'h010000; #1; chk("R1 at floor", {31'd0, cyc_allow}, 32'd1);
        cyc_write = 1'b1;
        cyc_addr = 24'h02FFFF; #1; chk("R3 last page inclusive", {31'd0, cyc_allow}, 32'd0);
        cyc_addr = 24'h030000; #1; chk("R3 past last page", {31'd0, cyc_allow}, 32'd1);
        cyc_addr = 24'h045000; #1; chk("R4 disabled window", {31'd0, cyc_allow}, 32'd1);
        cyc_write = 1'b0;
        cyc_addr = 24'h025000; #1; chk("R5 read inside window", {31'd0, cyc_allow}, 32'd1);
        cyc_valid = 1'b0;

        // Clear flag, then sticky set
        wr(3'd1, 32'h1);
        chk("R8 clear", {31'd0, blocked_sts}, 32'd0);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_write = 1'b1; cyc_addr = 24'h100800;
        @(negedge clk);
        cyc_valid = 1'b0;
        chk("R7 refusal sets flag", {31'd0, blocked_sts}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R7 flag sticky", {31'd0, blocked_sts}, 32'd1);
        wr(3'd1, 32'h0);
        chk("R8 zero write keeps", {31'd0, blocked_sts}, 32'd1);
        rd(3'd1, d); chk("R9 status readback", d, 32'h1);
        wr(3'd1, 32'h1);
        chk("R8 clear again", {31'd0, blocked_sts}, 32'd0);

        // Allowed cycle leaves flag clear
        @(negedge clk);
        cyc_valid = 1'b1; cyc_write = 1'b1; cyc_addr = 24'h200000;
        @(negedge clk);
        cyc_valid = 1'b0;
        chk("R7 allowed keeps clear", {31'd0, blocked_sts}, 32'd0);

        // Refusal and clear on the same edge
        @(negedge clk);
        cyc_valid = 1'b1; cyc_write = 1'b0; cyc_addr = 24'h000010;
        cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 32'h1;
        @(negedge clk);
        cfg_we = 1'b0; cyc_valid = 1'b0;
        chk("R8 set wins over clear", {31'd0, blocked_sts}, 32'd1);

        // Lock
        wr(3'd1, 32'h2);
        rd(3'd1, d); chk("R6 lock set", d, 32'h3);
        wr(3'd0, 32'h00000000);
        rd(3'd0, d); chk("R6 floor frozen", d, 32'hFF010000);
        wr(3'd2, 32'h00000000);
        rd(3'd2, d); chk("R6 window frozen", d, 32'h8002F020);
        wr(3'd3, 32'h80FFF000);
        rd(3'd3, d); chk("R6 window1 frozen", d, 32'h0004F040);
        wr(3'd1, 32'h0);
        rd(3'd1, d); chk("R6 lock sticky", d, 32'h3);
        wr(3'd1, 32'h1);
        rd(3'd1, d); chk("R8 clear while locked", d, 32'h2);
        @(negedge clk);
        sweep(80);

        // Reset clears lock
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd1, d); chk("R6 reset clears lock", d, 32'h0);
        wr(3'd0, 32'h00000100);
        rd(3'd0, d); chk("R6 writable after reset", d, 32'hFF000100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule